// File: doc/BRIEF.md
# Configuration Packet CRC Accumulator

This block keeps a running 32-bit checksum over a stream of configuration write packets whose payload is made of 16-bit words. It receives an already decoded stream. A header beat carries the write flag, a 6-bit target register address and a word count. Payload beats follow, one 16-bit word each. Every accumulated payload word is shifted into a CRC-32C engine one bit per clock, followed by the address of the register it targets. While that happens the block holds its ready output low.

Some writes control the engine instead of feeding it. A command-register write whose first word is the reset code clears the checksum. A write to the checksum register supplies an expected value, which is compared with the running value; the running value is then cleared. With automatic checking enabled, the two raw words that come after a frame-data write are treated the same way. Every comparison gives a one-cycle match or mismatch pulse. The value that was compared stays on an output until the next comparison.

Top module: `cfg_crc_accum`

## Requirements
- R1: The checksum uses the generator 0x1EDC6F41 in non-reflected form. Per input bit b, the new value is ({crc[30:0],0}) XOR (0x1EDC6F41 if crc[31]^b). The value starts at zero after reset and after any clear. No final XOR and no output reflection are applied.
- R2: For each accumulated word, 22 bits enter in this order: data bits 0 to 15, then address bits 0 to 5 of the packet's target register.
- R3: A beat is accepted on a rising edge where in_valid and in_ready are both high. After an accumulated word is accepted, in_ready is low for exactly 22 cycles and then returns high. Clears and compares never lower it.
- R4: A header beat has in_hdr=1 and carries in_write, in_addr and in_count. Payload of a read header (in_write=0) is consumed with no effect. A write header with in_count=0 has no effect. An idle cycle changes nothing.
- R5: Address 0x05 is the command register. A write there whose first payload word is 0x0007 clears the checksum, and no word of that packet is accumulated. Any other first word makes the whole packet accumulate normally.
- R6: Address 0x00 is the checksum register, and writes to it are never accumulated. Its first payload word is the upper half of the expected value and its second word is the lower half. On the second word the expected value is compared with the running checksum, and the checksum is cleared. Further words are ignored.
- R7: Address 0x02 is the frame-data register. When auto_crc_en=1, the two payload beats that follow the last word of a frame-data write (upper half, then lower half) are an expected value, handled as in R6. A header beat in between cancels this. When auto_crc_en=0, such beats are ignored.
- R8: crc_ok or crc_err is high for exactly the one cycle after the edge that accepts the lower expected half. The two are never high together. crc_last then shows the checksum that was compared and holds it until the next comparison.
- R9: While rst_n is low, crc_now, crc_last, crc_ok and crc_err are zero, in_ready is high, and all packet tracking is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_crc_en | input | 1 | Enables checking of the two words after a frame-data write |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Block can take a beat |
| in_hdr | input | 1 | 1 = header beat, 0 = payload beat |
| in_write | input | 1 | Header: 1 = write packet |
| in_addr | input | 6 | Header: target register address |
| in_count | input | 11 | Header: payload word count |
| in_data | input | 16 | Payload word |
| crc_now | output | 32 | Running checksum |
| crc_ok | output | 1 | One-cycle pulse: expected value matched |
| crc_err | output | 1 | One-cycle pulse: expected value differed |
| crc_last | output | 32 | Checksum compared at the latest check |

## Verification
The bench builds the block with its default widths: 16-bit words, 6-bit addresses and the three special addresses at 0x00, 0x02 and 0x05. At that size a sweep of all 22 single-bit input positions is short, and so is a sweep of every ordinary address. Together they pin down the bit order of R1 and R2 against an arithmetic model. The same small setup makes the ready window, all three control paths, both compare outcomes and the cancellation of a pending automatic check cheap to reach directly.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
  // What an accepted payload word does to the checksum engine
  typedef enum logic [2:0] {
    WC_DROP   = 3'd0,
    WC_ACCUM  = 3'd1,
    WC_CLEAR  = 3'd2,
    WC_EXP_HI = 3'd3,
    WC_EXP_LO = 3'd4
  } word_class_e;
endpackage

// File: rtl/ccrc_tracker.sv
module ccrc_tracker
  import cfg_crc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 11,
  parameter logic [ADDR_W-1:0] CRC_ADDR  = 6'h00,
  parameter logic [ADDR_W-1:0] FDRI_ADDR = 6'h02,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 6'h05,
  parameter logic [DATA_W-1:0] RCRC_CODE = 16'h0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic              beat_hdr,
  input  logic              beat_write,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [CNT_W-1:0]  beat_count,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              auto_en,
  output word_class_e       word_cls,
  output logic [ADDR_W-1:0] cur_addr
);
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [1:0]        idx_q, idx_d;
  logic              skip_q, skip_d;
  logic [1:0]        pend_q, pend_d;
  word_class_e       cls;

  // Classification of the current payload beat
  always_comb begin
    cls = WC_DROP;
    if (rem_q != '0) begin
      if (!wr_q)                   cls = WC_DROP;
      else if (addr_q == CRC_ADDR) cls = (idx_q == 2'd0) ? WC_EXP_HI :
                                         (idx_q == 2'd1) ? WC_EXP_LO : WC_DROP;
      else if (addr_q == CMD_ADDR) begin
        if (idx_q == 2'd0 && beat_data == RCRC_CODE) cls = WC_CLEAR;
        else if (skip_q)                              cls = WC_DROP;
        else                                          cls = WC_ACCUM;
      end else                     cls = WC_ACCUM;
    end else if (pend_q == 2'd2)   cls = WC_EXP_HI;
    else if (pend_q == 2'd1)       cls = WC_EXP_LO;
  end

  assign word_cls = (beat_en && !beat_hdr) ? cls : WC_DROP;
  assign cur_addr = addr_q;

  // Next packet-tracking state
  always_comb begin
    wr_d = wr_q; addr_d = addr_q; rem_d = rem_q;
    idx_d = idx_q; skip_d = skip_q; pend_d = pend_q;
    if (beat_hdr) begin
      wr_d = beat_write; addr_d = beat_addr; rem_d = beat_count;
      idx_d = 2'd0; skip_d = 1'b0; pend_d = 2'd0;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
      if (idx_q != 2'd2) idx_d = idx_q + 2'd1;
      if (cls == WC_CLEAR) skip_d = 1'b1;
      if (wr_q && addr_q == FDRI_ADDR && rem_q == CNT_W'(1) && auto_en)
        pend_d = 2'd2;
    end else if (pend_q != 2'd0) begin
      pend_d = pend_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; addr_q <= '0; rem_q <= '0;
      idx_q <= 2'd0; skip_q <= 1'b0; pend_q <= 2'd0;
    end else if (beat_en) begin
      wr_q <= wr_d; addr_q <= addr_d; rem_q <= rem_d;
      idx_q <= idx_d; skip_q <= skip_d; pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ccrc_lfsr.sv
module ccrc_lfsr #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h1EDC6F41
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [DATA_W+ADDR_W-1:0]   load_bits,
  input  logic                       clear,
  output logic                       busy,
  output logic [CRC_W-1:0]           crc
);
  localparam int SHIFT_W = DATA_W + ADDR_W;
  localparam int BC_W    = $clog2(SHIFT_W + 1);

  logic [SHIFT_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]    cnt_q, cnt_d;
  logic [CRC_W-1:0]   crc_q, crc_d;
  logic               fb;

  assign fb = crc_q[CRC_W-1] ^ sh_q[0];

  always_comb begin
    sh_d = sh_q; cnt_d = cnt_q; crc_d = crc_q;
    if (clear) crc_d = '0;
    if (load) begin
      sh_d  = load_bits;
      cnt_d = BC_W'(SHIFT_W);
    end else if (cnt_q != '0) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; crc_q <= '0;
    end else begin
      sh_q <= sh_d; cnt_q <= cnt_d; crc_q <= crc_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign crc  = crc_q;
endmodule

// File: rtl/ccrc_compare.sv
module ccrc_compare #(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic [DATA_W-1:0] word,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              ok,
  output logic              err,
  output logic [CRC_W-1:0]  last
);
  logic [DATA_W-1:0] hi_q;
  logic              ok_d, err_d, match;
  logic [CRC_W-1:0]  expect_v;

  assign expect_v = CRC_W'({hi_q, word});
  assign match    = (expect_v == crc_in);

  always_comb begin
    ok_d  = lo_en &&  match;
    err_d = lo_en && !match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; ok <= 1'b0; err <= 1'b0; last <= '0;
    end else begin
      ok  <= ok_d;
      err <= err_d;
      if (hi_en) hi_q <= word;
      if (lo_en) last <= crc_in;
    end
  end
endmodule

// File: rtl/cfg_crc_accum.sv
module cfg_crc_accum
  import cfg_crc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 11,
  parameter int CRC_W  = 32,
  parameter logic [CRC_W-1:0]  POLY      = 32'h1EDC6F41,
  parameter logic [ADDR_W-1:0] CRC_ADDR  = 6'h00,
  parameter logic [ADDR_W-1:0] FDRI_ADDR = 6'h02,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 6'h05,
  parameter logic [DATA_W-1:0] RCRC_CODE = 16'h0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_crc_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_hdr,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [DATA_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_now,
  output logic              crc_ok,
  output logic              crc_err,
  output logic [CRC_W-1:0]  crc_last
);
  logic              accept, busy;
  word_class_e       cls;
  logic [ADDR_W-1:0] cur_addr;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  ccrc_tracker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CRC_ADDR(CRC_ADDR), .FDRI_ADDR(FDRI_ADDR),
    .CMD_ADDR(CMD_ADDR), .RCRC_CODE(RCRC_CODE)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .beat_en(accept), .beat_hdr(in_hdr),
    .beat_write(in_write), .beat_addr(in_addr), .beat_count(in_count),
    .beat_data(in_data), .auto_en(auto_crc_en),
    .word_cls(cls), .cur_addr(cur_addr)
  );

  ccrc_lfsr #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CRC_W(CRC_W), .POLY(POLY)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .load(cls == WC_ACCUM), .load_bits({cur_addr, in_data}),
    .clear(cls == WC_CLEAR || cls == WC_EXP_LO),
    .busy(busy), .crc(crc_now)
  );

  ccrc_compare #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .hi_en(cls == WC_EXP_HI), .lo_en(cls == WC_EXP_LO),
    .word(in_data), .crc_in(crc_now),
    .ok(crc_ok), .err(crc_err), .last(crc_last)
  );
endmodule

// File: rtl/ccrc_checker.sv
module ccrc_checker #(
  parameter int CRC_W   = 32,
  parameter int SHIFT_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CRC_W-1:0] crc_now,
  input logic             crc_ok,
  input logic             crc_err,
  input logic [CRC_W-1:0] crc_last
);
  localparam int RW = $clog2(SHIFT_W + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            run_q <= '0;
    else if (in_ready)                     run_q <= '0;
    else if (run_q != RW'(SHIFT_W + 1))    run_q <= run_q + 1'b1;
  end

  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_ok && crc_err));                                   // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok || crc_err) |=> !(crc_ok || crc_err));           // R8
  AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_ok || crc_err) |-> $stable(crc_last));             // R8
  AST_CHECK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok || crc_err) |-> (crc_now == '0));                // R6
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(crc_now));           // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(SHIFT_W));                                  // R3
  AST_BUSY_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !(crc_ok || crc_err));                     // R3
endmodule

bind cfg_crc_accum ccrc_checker #(.CRC_W(CRC_W), .SHIFT_W(DATA_W + ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .crc_now(crc_now), .crc_ok(crc_ok), .crc_err(crc_err), .crc_last(crc_last)
);

// File: tb/tb_cfg_crc_accum.sv
module tb_cfg_crc_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auto_crc_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_hdr = 1'b0;
  logic        in_write = 1'b0;
  logic [5:0]  in_addr = '0;
  logic [10:0] in_count = '0;
  logic [15:0] in_data = '0;
  logic        in_ready, crc_ok, crc_err;
  logic [31:0] crc_now, crc_last;

  int checks = 0, errors = 0;
  logic [31:0] mc, held;

  always #5 clk = ~clk;

  cfg_crc_accum dut (
    .clk(clk), .rst_n(rst_n), .auto_crc_en(auto_crc_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
    .in_write(in_write), .in_addr(in_addr), .in_count(in_count),
    .in_data(in_data), .crc_now(crc_now), .crc_ok(crc_ok),
    .crc_err(crc_err), .crc_last(crc_last)
  );

  // Arithmetic model of one accumulated word (R1, R2)
  function automatic logic [31:0] ref_step(input logic [31:0] c,
                                           input logic [15:0] d,
                                           input logic [5:0]  a);
    for (int i = 0; i < 22; i++) begin
      logic b, fb;
      b  = (i < 16) ? d[i] : a[i-16];
      fb = c[31] ^ b;
      c  = {c[30:0], 1'b0} ^ (fb ? 32'h1EDC6F41 : 32'h0);
    end
    return c;
  endfunction

  task automatic chk(input logic cond, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic h, input logic w, input logic [5:0] a,
                      input logic [10:0] n, input logic [15:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_hdr = h; in_write = w;
    in_addr = a; in_count = n; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic do_clear();
    beat(1'b1, 1'b1, 6'h05, 11'd1, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h0007);
    mc = '0;
  endtask

  task automatic acc_word(input logic [5:0] a, input logic [15:0] d);
    beat(1'b1, 1'b1, a, 11'd1, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, d);
    mc = ref_step(mc, d, a);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mc = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(crc_now == 0 && crc_last == 0, "R9 reset checksum", crc_now, 0);
    chk(in_ready && !crc_ok && !crc_err, "R9 reset flags",
        {29'd0, in_ready, crc_ok, crc_err}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: single-bit sweep over the 22 input positions
    for (int b = 0; b < 22; b++) begin
      do_clear();
      if (b < 16) acc_word(6'h10, 16'(1 << b));
      else        acc_word(6'(1 << (b - 16)), 16'h0);
      chk(crc_now == mc, "R1 R2 single-bit position", crc_now, mc);
    end

    // R2: every ordinary address, chained from a running value
    do_clear();
    for (int a = 1; a < 64; a++) begin
      if (a == 5) continue;
      acc_word(6'(a), 16'(a * 16'h0101 ^ 16'hA5C3));
      chk(crc_now == mc, "R2 address sweep", crc_now, mc);
    end

    // R3: ready window length
    begin
      int lows = 0;
      beat(1'b1, 1'b1, 6'h11, 11'd1, 16'h0);
      beat(1'b0, 1'b0, 6'h0, 11'd0, 16'hBEEF);
      mc = ref_step(mc, 16'hBEEF, 6'h11);
      while (!in_ready) begin lows++; @(negedge clk); end
      chk(lows == 22, "R3 ready low cycles", 32'(lows), 32'd22);
      chk(crc_now == mc, "R3 word complete", crc_now, mc);
    end

    // R2: multi-word packet
    beat(1'b1, 1'b1, 6'h21, 11'd3, 16'h0);
    for (int i = 0; i < 3; i++) begin
      beat(1'b0, 1'b0, 6'h0, 11'd0, 16'(16'h1357 * (i + 1)));
      mc = ref_step(mc, 16'(16'h1357 * (i + 1)), 6'h21);
    end
    wait_idle();
    chk(crc_now == mc, "R2 multi-word packet", crc_now, mc);

    // R4: read packet payload and empty write have no effect
    beat(1'b1, 1'b0, 6'h11, 11'd2, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h1111);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h2222);
    beat(1'b1, 1'b1, 6'h11, 11'd0, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h3333);
    repeat (3) @(negedge clk);
    chk(crc_now == mc, "R4 read and empty write ignored", crc_now, mc);

    // R5: command write with other first word accumulates
    beat(1'b1, 1'b1, 6'h05, 11'd2, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h1234);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h0007);
    mc = ref_step(ref_step(mc, 16'h1234, 6'h05), 16'h0007, 6'h05);
    wait_idle();
    chk(crc_now == mc, "R5 non-reset command accumulates", crc_now, mc);
    // R5: reset code clears, remainder skipped
    beat(1'b1, 1'b1, 6'h05, 11'd2, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h0007);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'hBEEF);
    repeat (2) @(negedge clk);
    chk(crc_now == 0 && in_ready, "R5 reset command clears", crc_now, 0);
    mc = '0;

    // R6 R8: matching check
    acc_word(6'h0A, 16'hC0DE);
    beat(1'b1, 1'b1, 6'h00, 11'd3, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[31:16]);
    chk(!crc_ok && !crc_err && in_ready, "R6 no pulse after upper half",
        {30'd0, crc_ok, crc_err}, 0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[15:0]);
    chk(crc_ok && !crc_err, "R6 match pulse", {30'd0, crc_ok, crc_err}, 32'h2);
    chk(crc_last == mc, "R8 held compared value", crc_last, mc);
    chk(crc_now == 0, "R6 cleared after check", crc_now, 0);
    held = mc; mc = '0;
    @(negedge clk);
    chk(!crc_ok && !crc_err, "R8 pulse lasts one cycle",
        {30'd0, crc_ok, crc_err}, 0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h5555);
    @(negedge clk);
    chk(crc_now == 0 && !crc_ok && !crc_err, "R6 third word ignored", crc_now, 0);
    chk(crc_last == held, "R8 value holds", crc_last, held);

    // R6 R8: mismatching check
    acc_word(6'h0B, 16'h7E57);
    beat(1'b1, 1'b1, 6'h00, 11'd2, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[31:16]);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[15:0] ^ 16'h0001);
    chk(!crc_ok && crc_err, "R6 mismatch pulse", {30'd0, crc_ok, crc_err}, 32'h1);
    chk(crc_last == mc && crc_now == 0, "R8 mismatch value", crc_last, mc);
    mc = '0;

    // R7: auto mode disabled ignores trailing words
    acc_word(6'h02, 16'hAAAA);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[31:16]);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[15:0]);
    chk(!crc_ok && !crc_err && crc_now == mc, "R7 disabled ignores", crc_now, mc);

    // R7: auto mode enabled checks the two trailing words
    auto_crc_en = 1'b1;
    beat(1'b1, 1'b1, 6'h02, 11'd2, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'h0F0F);
    beat(1'b0, 1'b0, 6'h0, 11'd0, 16'hF00D);
    mc = ref_step(ref_step(mc, 16'h0F0F, 6'h02), 16'hF00D, 6'h02);
    wait_idle();
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[31:16]);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[15:0]);
    chk(crc_ok && !crc_err, "R7 auto match", {30'd0, crc_ok, crc_err}, 32'h2);
    chk(crc_last == mc && crc_now == 0, "R7 auto compared value", crc_last, mc);
    held = mc; mc = '0;

    // R7: a header cancels the pending auto check
    acc_word(6'h02, 16'h4242);
    beat(1'b1, 1'b0, 6'h00, 11'd0, 16'h0);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[31:16]);
    beat(1'b0, 1'b0, 6'h0, 11'd0, mc[15:0]);
    chk(!crc_ok && !crc_err && crc_now == mc, "R7 header cancels", crc_now, mc);
    chk(crc_last == held, "R8 value holds without check", crc_last, held);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule